// File: doc/BRIEF.md
# Program Fetch Steering Decoder

This block decides, for every instruction fetch, whether the address is served by the on-chip program ROM or goes out over the external multiplexed memory bus. The split point is held in a small size register that software may rewrite at run time. It can place all of the lowest 16 kB inside the chip, a smaller power-of-two portion of it, or none of it. An external-access pin overrides the register and sends every fetch off chip.

The size register is protected. A write to it takes effect only inside a short window that opens after a two-byte unlock sequence has been written to a separate unlock register. The window is measured in clock-enable cycles, so it lasts the same number of machine cycles whatever the clock ratio. The decode is combinational on the registered size, so a new size applies to the very next fetch after the accepted write.

Top module: `fetchSteer`

## Requirements
- R1: After reset the size register selects 16 kB: with the external pin high, a valid fetch at 3FFFh selects the ROM and a valid fetch at 4000h selects the external bus.
- R2: With the external pin high, a valid fetch is internal exactly when its address is below the selected limit. The size codes are 001=1 kB, 010=2 kB, 011=4 kB, 100=8 kB and 101=16 kB. Any address at or above the limit is external.
- R3: Size code 000 makes every valid fetch in the full 64 kB space external.
- R4: Size codes 110 and 111 act as 16 kB.
- R5: While extAccessN is low, every valid fetch is external, whatever the size register holds.
- R6: romSel and extSel are both low when fetchValid is low, and exactly one of them is high when it is high. progStoreN is low exactly when extSel is high.
- R7: A register write uses regWrSel=0 for the unlock register and regWrSel=1 for the size register, with the size in regWrData[2:0]. A size write is accepted only when AAh and then 55h have been written to the unlock register. Otherwise it is ignored and the decode is unchanged.
- R8: Writing AAh arms the lock for 3 clock-enable cycles, and writing 55h while armed opens the write window for 3 clock-enable cycles. A size write after the third such cycle is ignored. Cycles with cycleEn low do not count.
- R9: Any other unlock write clears the sequence: 55h without a preceding AAh, or some other value between AAh and 55h, leaves the size locked. Each size write closes the window, so a second size write needs a fresh unlock.
- R10: An accepted size write changes the decode for fetches presented after the clock edge that captures the write. Before that edge the old size still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycleEn | input | 1 | Clock-enable pulse that paces the unlock window |
| fetchAddr | input | 16 | Instruction fetch address |
| fetchValid | input | 1 | A fetch is requested in this cycle |
| extAccessN | input | 1 | External-access pin; low forces every fetch off chip |
| regWrEn | input | 1 | Register write strobe |
| regWrSel | input | 1 | 0 selects the unlock register, 1 selects the size register |
| regWrData | input | 8 | Register write data |
| romSel | output | 1 | Fetch is served by on-chip ROM |
| extSel | output | 1 | Fetch is served by the external bus |
| progStoreN | output | 1 | Active-low program store enable for external fetches |

## Verification
A wrong size register shows as a boundary that has moved. Fetches between the old and the new limit land on the wrong side, and this shows at the ports in the first fetch after the faulty edge. A wrong unlock state does not show by itself; it shows only when a protected write lands or fails to land. For that reason each protocol case ends with a boundary probe of the decode that the write should or should not have produced. The address sweeps cover every size code, with the pin both high and low, at every tier edge. A stale or mis-decoded limit is therefore caught at the edge it affects.

// File: rtl/fetchSteerPkg.sv
package fetchSteerPkg;
  localparam int SIZE_W = 3;

  typedef enum logic [1:0] {
    GATE_LOCKED = 2'd0,
    GATE_ARMED  = 2'd1,
    GATE_OPEN   = 2'd2
  } gateState_t;

  // Strobes from the unlock control to the size datapath
  typedef struct packed {
    logic              sizeLoad;
    logic [SIZE_W-1:0] sizeVal;
  } sizeStrobe_t;
endpackage

// File: rtl/fetchSteerCtrl.sv
module fetchSteerCtrl
  import fetchSteerPkg::*;
#(
  parameter logic [7:0] KEY_FIRST  = 8'hAA,
  parameter logic [7:0] KEY_SECOND = 8'h55,
  parameter int         WINDOW     = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cycleEn,
  input  logic        regWrEn,
  input  logic        regWrSel,
  input  logic [7:0]  regWrData,
  output sizeStrobe_t strobe
);
  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WINDOW);

  gateState_t     gateState;
  logic [CNT_W-1:0] gateCnt;

  logic unlockWr;
  logic sizeWr;
  assign unlockWr = regWrEn && !regWrSel;
  assign sizeWr   = regWrEn && regWrSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateState <= GATE_LOCKED;
      gateCnt   <= '0;
    end else if (unlockWr) begin
      if (regWrData == KEY_FIRST) begin
        gateState <= GATE_ARMED;
        gateCnt   <= CNT_FULL;
      end else if (regWrData == KEY_SECOND && gateState == GATE_ARMED) begin
        gateState <= GATE_OPEN;
        gateCnt   <= CNT_FULL;
      end else begin
        gateState <= GATE_LOCKED;
        gateCnt   <= '0;
      end
    end else if (sizeWr) begin
      gateState <= GATE_LOCKED;
      gateCnt   <= '0;
    end else if (cycleEn && gateState != GATE_LOCKED) begin
      if (gateCnt <= CNT_W'(1)) begin
        gateState <= GATE_LOCKED;
        gateCnt   <= '0;
      end else begin
        gateCnt <= gateCnt - CNT_W'(1);
      end
    end
  end

  always_comb begin
    strobe.sizeLoad = sizeWr && (gateState == GATE_OPEN);
    strobe.sizeVal  = regWrData[SIZE_W-1:0];
  end
endmodule

// File: rtl/fetchSteerPath.sv
module fetchSteerPath
  import fetchSteerPkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BASE_LOG2  = 10,
  parameter int MAX_STEP   = 5,
  parameter int RESET_CODE = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  sizeStrobe_t       strobe,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchValid,
  input  logic              extAccessN,
  output logic              romSel,
  output logic              extSel,
  output logic              progStoreN
);
  localparam int TIERS = MAX_STEP + 1;

  logic [SIZE_W-1:0] sizeReg;
  logic [TIERS-1:0]  fitsTier;
  logic [SIZE_W-1:0] effTier;
  logic              internalHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sizeReg <= SIZE_W'(RESET_CODE);
    else if (strobe.sizeLoad) sizeReg <= strobe.sizeVal;
  end

  // Tier k holds addresses below 2^(BASE_LOG2+k-1); tier 0 holds none
  assign fitsTier[0] = 1'b0;
  for (genvar k = 1; k < TIERS; k++) begin : gTier
    assign fitsTier[k] = (fetchAddr[ADDR_W-1:BASE_LOG2+k-1] == '0);
  end

  always_comb begin
    effTier = (sizeReg > SIZE_W'(MAX_STEP)) ? SIZE_W'(MAX_STEP) : sizeReg;
    internalHit = extAccessN && fitsTier[effTier];
    romSel      = fetchValid && internalHit;
    extSel      = fetchValid && !internalHit;
    progStoreN  = !extSel;
  end
endmodule

// File: rtl/fetchSteer.sv
module fetchSteer
  import fetchSteerPkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BASE_LOG2  = 10,
  parameter int MAX_STEP   = 5,
  parameter int RESET_CODE = 5,
  parameter int WINDOW     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleEn,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchValid,
  input  logic              extAccessN,
  input  logic              regWrEn,
  input  logic              regWrSel,
  input  logic [7:0]        regWrData,
  output logic              romSel,
  output logic              extSel,
  output logic              progStoreN
);
  sizeStrobe_t strobe;

  fetchSteerCtrl #(
    .KEY_FIRST (8'hAA),
    .KEY_SECOND(8'h55),
    .WINDOW    (WINDOW)
  ) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cycleEn  (cycleEn),
    .regWrEn  (regWrEn),
    .regWrSel (regWrSel),
    .regWrData(regWrData),
    .strobe   (strobe)
  );

  fetchSteerPath #(
    .ADDR_W    (ADDR_W),
    .BASE_LOG2 (BASE_LOG2),
    .MAX_STEP  (MAX_STEP),
    .RESET_CODE(RESET_CODE)
  ) path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .fetchAddr (fetchAddr),
    .fetchValid(fetchValid),
    .extAccessN(extAccessN),
    .romSel    (romSel),
    .extSel    (extSel),
    .progStoreN(progStoreN)
  );
endmodule

// File: rtl/fetchSteerChecker.sv
module fetchSteerChecker #(
  parameter int ADDR_W    = 16,
  parameter int BASE_LOG2 = 10,
  parameter int MAX_STEP  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              fetchValid,
  input logic              extAccessN,
  input logic              romSel,
  input logic              extSel,
  input logic              progStoreN
);
  localparam int CEIL_LOG2 = BASE_LOG2 + MAX_STEP - 1;

  // R5: the pin forces the external path
  assert_pin_override_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !extAccessN) |-> (extSel && !romSel));

  // R6: a valid fetch has exactly one target
  assert_one_target_R6: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> (romSel ^ extSel));

  // R6: no fetch, no select
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |-> (!romSel && !extSel && progStoreN));

  // R6: program store enable follows the external select
  assert_strobe_match_R6: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> (progStoreN == romSel));

  // R2: nothing at or above the largest limit is ever internal
  assert_rom_ceiling_R2: assert property (@(posedge clk) disable iff (!rstN)
    romSel |-> (fetchAddr[ADDR_W-1:CEIL_LOG2] == '0));
endmodule

bind fetchSteer fetchSteerChecker #(
  .ADDR_W   (ADDR_W),
  .BASE_LOG2(BASE_LOG2),
  .MAX_STEP (MAX_STEP)
) chk (
  .clk       (clk),
  .rstN      (rstN),
  .fetchAddr (fetchAddr),
  .fetchValid(fetchValid),
  .extAccessN(extAccessN),
  .romSel    (romSel),
  .extSel    (extSel),
  .progStoreN(progStoreN)
);

// File: tb/fetchSteer_test.sv
`timescale 1ns/1ps
module fetchSteer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cycleEn = 1'b1;
  logic [15:0] fetchAddr = '0;
  logic        fetchValid = 1'b0;
  logic        extAccessN = 1'b1;
  logic        regWrEn = 1'b0;
  logic        regWrSel = 1'b0;
  logic [7:0]  regWrData = '0;
  logic        romSel, extSel, progStoreN;

  int vecCount = 0;
  int failCount = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fetchSteer uut (
    .clk(clk), .rstN(rstN), .cycleEn(cycleEn),
    .fetchAddr(fetchAddr), .fetchValid(fetchValid), .extAccessN(extAccessN),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .romSel(romSel), .extSel(extSel), .progStoreN(progStoreN)
  );

  function automatic int limitOf(input int code);
    if (code == 0) return 0;
    if (code >= 5) return 16384;
    return 1024 << (code - 1);
  endfunction

  task automatic checkNow(input string req, input int code);
    logic expRom, expExt, expPse;
    expRom = fetchValid && extAccessN && (int'(fetchAddr) < limitOf(code));
    expExt = fetchValid && !expRom;
    expPse = !expExt;
    vecCount++;
    if ({romSel, extSel, progStoreN} !== {expRom, expExt, expPse}) begin
      failCount++;
      $display("FAIL %s addr=%h code=%0d pin=%b valid=%b rom/ext/pse got=%b%b%b exp=%b%b%b",
               req, fetchAddr, code, extAccessN, fetchValid,
               romSel, extSel, progStoreN, expRom, expExt, expPse);
    end
  endtask

  task automatic probe(input string req, input int addr, input int code);
    fetchAddr = 16'(addr); fetchValid = 1'b1; extAccessN = 1'b1;
    #0.1 checkNow(req, code);
  endtask

  // Quick boundary probe of a given size code, then realign to a falling edge
  task automatic probeCode(input string req, input int code);
    int lim;
    lim = limitOf(code);
    probe(req, 0, code);
    probe(req, 16'hFFFF, code);
    if (lim > 0) probe(req, lim - 1, code);
    if (lim < 65536) probe(req, lim, code);
    fetchValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic sweep(input string req, input int code);
    for (int a = 0; a < 65536; a += 64) begin
      for (int p = 0; p < 2; p++) begin
        fetchAddr = 16'(a); fetchValid = 1'b1; extAccessN = p[0];
        #0.5 checkNow(p == 0 ? "R5" : req, code);
      end
    end
    for (int t = 1; t < 6; t++) begin
      fetchAddr = 16'(limitOf(t) - 1); fetchValid = 1'b1; extAccessN = 1'b1;
      #0.5 checkNow(req, code);
      fetchAddr = 16'(limitOf(t));
      #0.5 checkNow(req, code);
    end
    fetchValid = 1'b0; fetchAddr = 16'h0000;
    #0.5 checkNow("R6", code);
    extAccessN = 1'b1;
    @(negedge clk);
  endtask

  // Called at a falling edge; the write is captured by the next rising edge
  task automatic wr(input logic sel, input logic [7:0] d);
    regWrEn = 1'b1; regWrSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlockSet(input int code);
    wr(1'b0, 8'hAA); wr(1'b0, 8'h55); wr(1'b1, 8'(code));
  endtask

  initial begin
    // R6 during reset
    #1 checkNow("R6", 5);
    tick(2);
    rstN = 1'b1;
    tick(1);

    // R1: reset boundary
    probe("R1", 16'h3FFF, 5);
    probe("R1", 16'h4000, 5);
    fetchValid = 1'b0;
    @(negedge clk);
    sweep("R1", 5);

    // R2 / R3 / R4: every size code
    for (int c = 0; c < 8; c++) begin
      unlockSet(c);
      sweep(c == 0 ? "R3" : (c > 5 ? "R4" : "R2"), c);
    end

    // Current code 7 (16 kB). R7: unprotected write ignored
    unlockSet(2);
    wr(1'b1, 8'h01);
    probeCode("R7", 2);

    // R9: 55h alone does not unlock
    wr(1'b0, 8'h55); wr(1'b1, 8'h04);
    probeCode("R9", 2);
    // R9: foreign value between the keys
    wr(1'b0, 8'hAA); wr(1'b0, 8'h12); wr(1'b0, 8'h55); wr(1'b1, 8'h04);
    probeCode("R9", 2);
    // R9: second size write needs a fresh unlock
    unlockSet(3); wr(1'b1, 8'h01);
    probeCode("R9", 3);

    // R8: write on the third enabled cycle of the window is accepted
    wr(1'b0, 8'hAA); wr(1'b0, 8'h55); tick(2); wr(1'b1, 8'h04);
    probeCode("R8", 4);
    // R8: after three enabled cycles it is ignored
    wr(1'b0, 8'hAA); wr(1'b0, 8'h55); tick(3); wr(1'b1, 8'h01);
    probeCode("R8", 4);
    // R8: arming also expires
    wr(1'b0, 8'hAA); tick(3); wr(1'b0, 8'h55); wr(1'b1, 8'h01);
    probeCode("R8", 4);
    // R8: cycles without enable do not count
    cycleEn = 1'b0;
    wr(1'b0, 8'hAA); tick(6); wr(1'b0, 8'h55); tick(6); wr(1'b1, 8'h01);
    cycleEn = 1'b1;
    probeCode("R8", 1);

    // R10: old size before the capturing edge, new size after it
    wr(1'b0, 8'hAA); wr(1'b0, 8'h55);
    regWrEn = 1'b1; regWrSel = 1'b1; regWrData = 8'h03;
    fetchAddr = 16'h0C00; fetchValid = 1'b1; extAccessN = 1'b1;
    #0.5 checkNow("R10", 1);
    @(posedge clk);
    #0.5 checkNow("R10", 3);
    @(negedge clk);
    regWrEn = 1'b0; fetchValid = 1'b0;
    probeCode("R10", 3);

    // R5: pin low with size 16 kB
    unlockSet(5);
    sweep("R5", 5);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end
endmodule